// File: doc/BRIEF.md
# SPI Master Peripheral with Completion and Collision Flags

This block is a byte-oriented SPI master controlled through three byte-wide registers: control, status and data. Software sets the enable, master and rate fields in the control register. It then writes a byte into the data register. The block shifts that byte out on MOSI, most significant bit first, in SPI mode 0. At the same time it gathers eight bits from MISO. When the eighth bit has been clocked, the received byte can be read back through the data register.

The block has two sticky flags in the status register. The completion flag is set at the end of every transfer. The collision flag is set when software writes the data register while a byte is still in flight; that write is thrown away. To clear a flag, software first reads the status register while the flag is set, and then reads or writes the data register. An interrupt-acknowledge pulse also clears the completion flag. The interrupt request is raised while the completion flag is set, provided the local interrupt enable and the global enable input are both on.

A slave-select input is watched for a mode fault. If the select line is configured as an input and is low while the block is an enabled master, the block stops any transfer, drops the master bit and sets the completion flag.

Top module: `spi_master_regs`

## Requirements
- R1: With the double-speed bit (status bit 0) clear, the rate field (control bits 1:0) values 0, 1, 2 and 3 give an SCK period of 4, 16, 64 and 128 clock cycles. SCK has 50% duty and stays low when no transfer is running.
- R2: With the double-speed bit set, the same rate values give SCK periods of 2, 8, 32 and 64 clock cycles.
- R3: Address 0 is control and reads {irq_en, enable, 0, master, 0, 0, rate[1:0]}, with irq_en at bit 7, enable at bit 6 and master at bit 4. Address 1 is status and reads {done, collision, 5'b0, double_speed}. Address 2 is data, and address 3 reads zero. After reset every register reads zero.
- R4: A data write while idle, with enable and master both set, starts an 8-bit mode-0 transfer. The block drives MSB first, changes MOSI on falling SCK edges, and samples MISO on rising edges. After the eighth falling edge, data reads return the received byte and the done flag (status bit 7) is set.
- R5: irq is high exactly when the done flag, irq_en and the gie input are all 1.
- R6: A data write during a transfer sets the collision flag (status bit 6). The written byte is discarded, and the byte in flight continues to shift unchanged.
- R7: A status read that sees a flag set arms that flag. The next data-register read or write clears every armed flag. A data access without such a prior status read leaves the flags unchanged.
- R8: A one-cycle irq_ack pulse clears the done flag.
- R9: When ss_is_input is 1, ss_n is 0, and enable and master are both set, any transfer is aborted, SCK returns low, the master bit is cleared and the done flag is set. With master clear, ss_n has no effect.
- R10: While master or enable is clear, a data write only loads the data register. It starts no transfer, SCK stays low and no flag is set, whatever the rate field holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the flag-clearing handshake) |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Slave-select line, active low |
| ss_is_input | input | 1 | Select line is configured as an input, so it is watched for a mode fault |

## Verification
The bench covers every rate code in both speed settings, including the two-cycle period. A divider that is off by one, or that ignores the double-speed bit, shows up at once as a wrong SCK edge. It writes the data register in the middle of a byte. A design that accepted that byte would send corrupted MOSI bits, and a design that skipped the flag would read back without bit 6. It makes a data access without first reading the status register, to catch a design that clears the flags on any data access. It also pulls the select line low in the middle of a transfer, which would expose a design that keeps clocking or leaves the master bit set.

// File: rtl/spi_master_regs.sv
module spi_master_regs #(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       gie,
  input  logic       irq_ack,
  output logic       irq,
  output logic       sck,
  output logic       mosi,
  input  logic       miso,
  input  logic       ss_n,
  input  logic       ss_is_input
);
  localparam logic [1:0] A_CTL = 2'd0;
  localparam logic [1:0] A_STS = 2'd1;
  localparam logic [1:0] A_DAT = 2'd2;

  logic             ie_q, en_q, mstr_q, dbl_q;
  logic [1:0]       rate_q;
  logic             done_q, coll_q, arm_done_q, arm_coll_q;
  logic             busy_q, sck_q, samp_q;
  logic [7:0]       sh_q;
  logic [2:0]       bits_q;
  logic [CNT_W-1:0] cnt_q, half_q, base, half_sel;

  wire wr_ctl  = reg_wr && reg_addr == A_CTL;
  wire wr_sts  = reg_wr && reg_addr == A_STS;
  wire rd_sts  = reg_rd && reg_addr == A_STS;
  wire wr_dat  = reg_wr && reg_addr == A_DAT;
  wire dat_acc = (reg_wr || reg_rd) && reg_addr == A_DAT;
  wire fault   = en_q && mstr_q && ss_is_input && !ss_n;
  wire start   = wr_dat && !busy_q && en_q && mstr_q && !fault;
  wire tick    = busy_q && cnt_q == half_q - CNT_W'(1);

  always_comb begin
    case (rate_q)
      2'd0:    base = CNT_W'(2);
      2'd1:    base = CNT_W'(8);
      2'd2:    base = CNT_W'(32);
      default: base = CNT_W'(64);
    endcase
    half_sel = dbl_q ? (base >> 1) : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= 1'b0; en_q <= 1'b0; mstr_q <= 1'b0; dbl_q <= 1'b0; rate_q <= 2'd0;
      done_q <= 1'b0; coll_q <= 1'b0; arm_done_q <= 1'b0; arm_coll_q <= 1'b0;
      busy_q <= 1'b0; sck_q <= 1'b0; samp_q <= 1'b0; sh_q <= 8'h00;
      bits_q <= 3'd0; cnt_q <= '0; half_q <= CNT_W'(2);
    end else begin
      if (wr_ctl) begin
        ie_q   <= reg_wdata[7];
        en_q   <= reg_wdata[6];
        mstr_q <= reg_wdata[4];
        rate_q <= reg_wdata[1:0];
      end
      if (wr_sts) dbl_q <= reg_wdata[0];
      if (rd_sts) begin
        if (done_q) arm_done_q <= 1'b1;
        if (coll_q) arm_coll_q <= 1'b1;
      end
      if (dat_acc) begin
        if (arm_done_q) done_q <= 1'b0;
        if (arm_coll_q) coll_q <= 1'b0;
        arm_done_q <= 1'b0;
        arm_coll_q <= 1'b0;
      end
      if (irq_ack) begin
        done_q     <= 1'b0;
        arm_done_q <= 1'b0;
      end
      if (wr_dat) begin
        if (busy_q) coll_q <= 1'b1;
        else begin
          sh_q <= reg_wdata;
          if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            bits_q <= 3'd0;
            sck_q  <= 1'b0;
            half_q <= half_sel;
          end
        end
      end
      if (busy_q) begin
        if (tick) begin
          cnt_q <= '0;
          sck_q <= ~sck_q;
          if (!sck_q) samp_q <= miso;
          else begin
            sh_q   <= {sh_q[6:0], samp_q};
            bits_q <= bits_q + 3'd1;
            if (bits_q == 3'd7) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
      if (fault) begin
        busy_q <= 1'b0;
        sck_q  <= 1'b0;
        mstr_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTL:   reg_rdata = {ie_q, en_q, 1'b0, mstr_q, 2'b00, rate_q};
      A_STS:   reg_rdata = {done_q, coll_q, 5'b00000, dbl_q};
      A_DAT:   reg_rdata = sh_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq  = done_q & ie_q & gie;
  assign sck  = sck_q;
  assign mosi = sh_q[7];

  p_sck_moves_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sck_q) |-> $past(busy_q));
  p_sck_low_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q);
  p_end_sets_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  p_coll_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && busy_q) |=> coll_q);
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !busy_q && !fault) |=> !done_q);
  p_fault_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!busy_q && !mstr_q && !sck_q && done_q));
endmodule

// File: tb/spi_master_regs_tb_top.sv
module spi_master_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic gie = 1'b0, irq_ack = 1'b0, irq, sck, mosi, miso;
  logic ss_n = 1'b1, ss_is_input = 1'b0;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  spi_master_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gie(gie), .irq_ack(irq_ack), .irq(irq), .sck(sck), .mosi(mosi),
    .miso(miso), .ss_n(ss_n), .ss_is_input(ss_is_input)
  );

  // behavioural reference model
  logic m_ie, m_en, m_mstr, m_dbl, m_done, m_coll, m_arm_d, m_arm_c, m_busy, m_mosi_ok;
  logic [1:0] m_rate;
  logic [7:0] m_data, m_tx, slv;
  int m_n, m_half;

  function automatic int half_of(logic [1:0] r, logic d);
    int div;
    case (r)
      2'd0: div = 4;
      2'd1: div = 16;
      2'd2: div = 64;
      default: div = 128;
    endcase
    if (d) div = div / 2;
    return div / 2;
  endfunction

  function automatic int bit_idx();
    int i = m_n / (2 * m_half);
    return (i > 7) ? 7 : i;
  endfunction

  assign miso = m_busy ? slv[7 - bit_idx()] : 1'b0;

  wire m_fault = m_en && m_mstr && ss_is_input && !ss_n;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ie <= 0; m_en <= 0; m_mstr <= 0; m_dbl <= 0; m_rate <= 0;
      m_done <= 0; m_coll <= 0; m_arm_d <= 0; m_arm_c <= 0; m_busy <= 0;
      m_mosi_ok <= 1; m_data <= 0; m_tx <= 0; m_n <= 0; m_half <= 2;
    end else begin
      if (reg_wr && reg_addr == 2'd0) begin
        m_ie <= reg_wdata[7]; m_en <= reg_wdata[6];
        m_mstr <= reg_wdata[4]; m_rate <= reg_wdata[1:0];
      end
      if (reg_wr && reg_addr == 2'd1) m_dbl <= reg_wdata[0];
      if (reg_rd && reg_addr == 2'd1) begin
        if (m_done) m_arm_d <= 1;
        if (m_coll) m_arm_c <= 1;
      end
      if ((reg_rd || reg_wr) && reg_addr == 2'd2) begin
        if (m_arm_d) m_done <= 0;
        if (m_arm_c) m_coll <= 0;
        m_arm_d <= 0; m_arm_c <= 0;
      end
      if (irq_ack) begin m_done <= 0; m_arm_d <= 0; end
      if (reg_wr && reg_addr == 2'd2) begin
        if (m_busy) m_coll <= 1;
        else begin
          m_data <= reg_wdata; m_mosi_ok <= 1;
          if (m_en && m_mstr && !m_fault) begin
            m_busy <= 1; m_n <= 0; m_tx <= reg_wdata;
            m_half <= half_of(m_rate, m_dbl);
          end
        end
      end
      if (m_busy) begin
        m_n <= m_n + 1;
        if (m_n + 1 == 16 * m_half) begin
          m_busy <= 0; m_done <= 1; m_data <= slv;
        end
      end
      if (m_fault) begin
        m_busy <= 0; m_mstr <= 0; m_done <= 1;
        if (m_busy) m_mosi_ok <= 0;
      end
    end
  end

  // per-clock comparison of the serial and interrupt outputs
  always @(negedge clk) begin
    if (rst_n) begin
      logic e_sck, e_mosi, e_irq;
      e_sck  = m_busy ? ((m_n / m_half) % 2 == 1) : 1'b0;
      e_mosi = m_busy ? m_tx[7 - bit_idx()] : m_data[7];
      e_irq  = m_done & m_ie & gie;
      n_tests++;
      if (sck !== e_sck) begin
        n_fail++;
        $display("FAIL R1/R2 sck at cycle %0d: got %b expected %b", cyc, sck, e_sck);
      end
      if (m_mosi_ok) begin
        n_tests++;
        if (mosi !== e_mosi) begin
          n_fail++;
          $display("FAIL R4 mosi at cycle %0d: got %b expected %b", cyc, mosi, e_mosi);
        end
      end
      n_tests++;
      if (irq !== e_irq) begin
        n_fail++;
        $display("FAIL R5 irq at cycle %0d: got %b expected %b", cyc, irq, e_irq);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input string tag);
    logic [7:0] e;
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1;
    case (a)
      2'd0: e = {m_ie, m_en, 1'b0, m_mstr, 2'b00, m_rate};
      2'd1: e = {m_done, m_coll, 5'b00000, m_dbl};
      2'd2: e = m_data;
      default: e = 8'h00;
    endcase
    n_tests++;
    if (reg_rdata !== e) begin
      n_fail++;
      $display("FAIL %s addr %0d: got %h expected %h", tag, a, reg_rdata, e);
    end
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
  endtask

  task automatic xfer(input logic [1:0] r, input logic d, input logic [7:0] tx,
                      input logic [7:0] rx, input string tag);
    slv = rx;
    wr(2'd1, {7'd0, d});
    wr(2'd0, {8'hD0 | {6'd0, r}});
    wr(2'd2, tx);
    wait_idle();
    rd_chk(2'd1, tag);
    rd_chk(2'd2, tag);
    pulse_ack();
    rd_chk(2'd1, "R8 ack clears done");
  endtask

  initial begin
    slv = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 reset state
    rd_chk(2'd0, "R3 reset ctl");
    rd_chk(2'd1, "R3 reset sts");
    rd_chk(2'd2, "R3 reset data");
    rd_chk(2'd3, "R3 unused addr");
    gie = 1'b1;
    // R4 basic transfer with handshake clear (R7)
    slv = 8'h3C;
    wr(2'd0, 8'hD0);
    wr(2'd1, 8'hFE);
    rd_chk(2'd1, "R3 reserved status bits");
    wr(2'd2, 8'hA5);
    wait_idle();
    rd_chk(2'd1, "R4 done flag");
    rd_chk(2'd2, "R4 received byte / R7 clear access");
    rd_chk(2'd1, "R7 flags cleared");
    // R1 / R2 all rates
    for (int r = 1; r < 4; r++) xfer(r[1:0], 1'b0, 8'h96 ^ r[7:0], 8'h5A + r[7:0], "R1 rate");
    for (int r = 0; r < 4; r++) xfer(r[1:0], 1'b1, 8'hC3 + r[7:0], 8'h81 ^ r[7:0], "R2 double rate");
    rd_chk(2'd0, "R3 ctl readback");
    // R6 collision
    slv = 8'hE7;
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hD1);
    wr(2'd2, 8'h0F);
    repeat (20) @(negedge clk);
    wr(2'd2, 8'hFF);
    wait_idle();
    rd_chk(2'd1, "R6 collision flag");
    rd_chk(2'd2, "R6 byte kept / R7 data access without status read");
    rd_chk(2'd1, "R7 flags remain without armed read");
    rd_chk(2'd2, "R7 clearing access");
    rd_chk(2'd1, "R7 both flags cleared");
    // R5 gating
    wr(2'd2, 8'h11);
    wait_idle();
    gie = 1'b0;
    repeat (3) @(negedge clk);
    rd_chk(2'd1, "R5 flag set with gie low");
    gie = 1'b1;
    wr(2'd0, 8'h51);
    repeat (3) @(negedge clk);
    wr(2'd0, 8'hD1);
    pulse_ack();
    // R9 mode fault
    ss_is_input = 1'b1;
    wr(2'd2, 8'h77);
    repeat (25) @(negedge clk);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    rd_chk(2'd0, "R9 master cleared");
    rd_chk(2'd1, "R9 done set");
    ss_n = 1'b1;
    pulse_ack();
    // R9 select ignored when not master, R10 no transfer
    wr(2'd0, 8'hC3);
    ss_n = 1'b0;
    repeat (6) @(negedge clk);
    rd_chk(2'd1, "R9 no fault when not master");
    wr(2'd2, 8'h5A);
    repeat (40) @(negedge clk);
    rd_chk(2'd1, "R10 no flag");
    rd_chk(2'd2, "R10 data loaded");
    ss_n = 1'b1;
    wr(2'd0, 8'h13);
    wr(2'd2, 8'h24);
    repeat (40) @(negedge clk);
    rd_chk(2'd1, "R10 disabled no flag");
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d: got running expected finished", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule